// File: doc/BRIEF.md
# Round-Robin Comparator Channel Scanner

This block steps a single analog comparator across a bank of input channels. One comparator input is held on a chosen fixed channel. The other input is moved through every remaining channel in ascending order and wraps around at the end. The block drives two mux select buses, one for the plus input and one for the minus input. On each visited channel it waits a programmable number of scan ticks and then latches the comparator output into that channel's result bit.

When a freshly latched bit differs from the value already held for that channel, a sticky per-channel changed flag is set. Software clears a flag by writing a one to it. An enabled interrupt is raised while any flag is set. Scanning begins after an initialization wait that lets the comparator and DAC settle. Dropping the enable returns the block to rest at any point.

The controller is a three-state machine. `ST_IDLE` is the rest state. `ST_SETTLE` runs the initialization wait. `ST_DWELL` holds a channel and counts toward its capture. The transitions are:
- start: `ST_IDLE` to `ST_SETTLE` when the enable is high.
- settled: `ST_SETTLE` to `ST_DWELL` on the last wait tick, which loads the first channel.
- capture-and-advance: `ST_DWELL` to itself on the capture tick.
- abort: `ST_SETTLE` or `ST_DWELL` to `ST_IDLE` when the enable is low.

Top module: `rr_cmp_scanner`

## Requirements
- R1: After reset the result vector, the changed flags and the interrupt are all zero, and both mux selects show the fixed channel.
- R2: With `sweep_plus_i` = 0 the plus select carries `ref_ch_i` and the minus select carries the swept channel. With `sweep_plus_i` = 1 the roles are exchanged. Outside `ST_DWELL` the swept select also shows `ref_ch_i`.
- R3: The swept channel advances in ascending index order, skips `ref_ch_i` and wraps from channel 7 to channel 0.
- R4: The sample-delay field `smp_dly_i` sets how long each channel is held. Value 0 holds the channel for 1 scan tick. A value d of 1, 2 or 3 holds it for d+2 scan ticks. The comparator is latched on the last tick of the hold, and the next channel is selected in the same clock.
- R5: On a capture, bit n of `result_o`, where n is the swept channel, takes the value of `cmp_out_i`. No other result bit changes. Without a capture the result is unchanged.
- R6: A capture sets `changed_o[n]` when the latched value differs from the stored `result_o[n]`. A capture of an equal value leaves the flag as it was.
- R7: A one in `flag_clr_i[n]` clears `changed_o[n]` at the next clock. If the same clock also sets that flag, the flag stays set.
- R8: `irq_o` is registered. At each clock it takes the value of `irq_en_i` ANDed with the OR of the flags' new values. With the enable low the interrupt stays low.
- R9: One clock after the enable rises, the block enters `ST_SETTLE`. The first channel is selected on the N-th scan tick in that state, where N is `init_mod_i`, or 64 when `init_mod_i` is 0.
- R10: With `scan_en_i` low the block returns to `ST_IDLE` at the next clock and makes no further captures. Enabling it again restarts the initialization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Scanning enable |
| tick_i | input | 1 | Scan clock enable, one pulse per scan tick |
| ref_ch_i | input | 3 | Fixed channel index |
| sweep_plus_i | input | 1 | 0: minus input swept, 1: plus input swept |
| smp_dly_i | input | 2 | Sample-delay code |
| init_mod_i | input | 6 | Initialization wait in ticks, 0 means 64 |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_out_i | input | 1 | Comparator output |
| flag_clr_i | input | 8 | Write-one-to-clear strobes for the changed flags |
| plus_sel_o | output | 3 | Plus input mux select |
| minus_sel_o | output | 3 | Minus input mux select |
| result_o | output | 8 | Latest comparison result for each channel |
| changed_o | output | 8 | Sticky changed flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `ref_ch_i`, `sweep_plus_i`, `smp_dly_i` and `init_mod_i` do not change while scanning is enabled. The check that the swept channel never equals the fixed channel relies on this assumption. The random stimulus therefore changes configuration only in cycles where the enable is low and stays low. Tick pulses, comparator values, clear strobes and the interrupt enable are randomized freely. Directed runs cover the 64-tick initialization case, wrap-around past a fixed channel 7, and a clear that collides with a set.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DWELL  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
    import rrs_pkg::*;
#(
    parameter int INIT_W = 6,
    parameter int DLY_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scan_en_i,
    input  logic              tick_i,
    input  logic [INIT_W-1:0] init_mod_i,
    input  logic [DLY_W-1:0]  smp_dly_i,
    output scan_state_e       state_o,
    output logic              load_first_o,
    output logic              capture_o
);
    localparam int CNT_W  = INIT_W + 1;
    localparam int HOLD_W = DLY_W + 1;
    localparam logic [CNT_W-1:0] INIT_FULL = CNT_W'(1) << INIT_W;

    scan_state_e       state_q, state_d;
    logic [CNT_W-1:0]  init_cnt_q;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [CNT_W-1:0]  init_load;
    logic [HOLD_W-1:0] hold_load;
    logic              settle_done;
    logic              dwell_done;

    // Zero in the modulus field stands for the full 2**INIT_W count.
    assign init_load = (init_mod_i == '0) ? INIT_FULL : {1'b0, init_mod_i};
    // Ticks remaining after the first dwell tick: 0, or code + 1.
    assign hold_load = (smp_dly_i == '0) ? '0 : ({1'b0, smp_dly_i} + HOLD_W'(1));

    assign settle_done = tick_i && (init_cnt_q == CNT_W'(1));
    assign dwell_done  = tick_i && (hold_cnt_q == '0);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (scan_en_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!scan_en_i)       state_d = ST_IDLE;
                else if (settle_done) state_d = ST_DWELL;
            end
            ST_DWELL: begin
                if (!scan_en_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        load_first_o = 1'b0;
        capture_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: load_first_o = scan_en_i && settle_done;
            ST_DWELL:  capture_o    = scan_en_i && dwell_done;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // Initialization and dwell counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            init_cnt_q <= '0;
            hold_cnt_q <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                init_cnt_q <= init_load;
            end else if ((state_q == ST_SETTLE) && tick_i) begin
                init_cnt_q <= init_cnt_q - CNT_W'(1);
            end

            if (load_first_o || capture_o) begin
                hold_cnt_q <= hold_load;
            end else if ((state_q == ST_DWELL) && tick_i) begin
                hold_cnt_q <= hold_cnt_q - HOLD_W'(1);
            end
        end
    end

    // R10: a low enable always lands in the rest state
    a_r10_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scan_en_i |=> (state_q == ST_IDLE));

    // R9: the wait counter never runs dry while waiting
    a_r9_settle_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SETTLE) |-> (init_cnt_q != '0));
endmodule

// File: rtl/rrs_chan_ptr.sv
module rrs_chan_ptr #(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] ref_i,
    input  logic             load_first_i,
    input  logic             advance_i,
    output logic [SEL_W-1:0] ch_o
);
    localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

    logic [SEL_W-1:0] ch_q;

    function automatic logic [SEL_W-1:0] wrap_inc(input logic [SEL_W-1:0] c);
        return (c == LAST_CH) ? '0 : (c + SEL_W'(1));
    endfunction

    function automatic logic [SEL_W-1:0] step_past(input logic [SEL_W-1:0] c,
                                                  input logic [SEL_W-1:0] r);
        logic [SEL_W-1:0] n;
        n = wrap_inc(c);
        if (n == r) n = wrap_inc(n);
        return n;
    endfunction

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else if (load_first_i) begin
            ch_q <= step_past(LAST_CH, ref_i);
        end else if (advance_i) begin
            ch_q <= step_past(ch_q, ref_i);
        end
    end

    assign ch_o = ch_q;

    // R3: a freshly chosen channel is never the fixed one
    a_r3_swept_not_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_first_i || advance_i) |=> (ch_o != $past(ref_i)));
endmodule

// File: rtl/rrs_result_bank.sv
module rrs_result_bank #(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [SEL_W-1:0]  ch_i,
    input  logic              cmp_i,
    input  logic [NUM_CH-1:0] clr_i,
    input  logic              irq_en_i,
    output logic [NUM_CH-1:0] result_o,
    output logic [NUM_CH-1:0] changed_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] res_q;
    logic [NUM_CH-1:0] flg_q;
    logic [NUM_CH-1:0] flg_d;
    logic              irq_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
        logic hit;
        logic differs;
        assign hit     = capture_i && (ch_i == SEL_W'(g));
        assign differs = hit && (cmp_i != res_q[g]);
        // A set in this clock beats a clear strobe in the same clock.
        assign flg_d[g] = differs | (flg_q[g] & ~clr_i[g]);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_q[g] <= 1'b0;
            end else if (hit) begin
                res_q[g] <= cmp_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flg_q <= '0;
            irq_q <= 1'b0;
        end else begin
            flg_q <= flg_d;
            irq_q <= irq_en_i && (|flg_d);
        end
    end

    assign result_o  = res_q;
    assign changed_o = flg_q;
    assign irq_o     = irq_q;

    // R7: a flag that was not cleared stays set
    a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((($past(changed_o) & ~$past(clr_i))) & ~changed_o) == '0));

    // R5: results only move on a capture
    a_r5_result_needs_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture_i |=> $stable(result_o));

    // R8: an interrupt only follows an enabled clock
    a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(irq_en_i));
endmodule

// File: rtl/rr_cmp_scanner.sv
module rr_cmp_scanner
    import rrs_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = $clog2(NUM_CH),
    parameter int INIT_W = 6,
    parameter int DLY_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scan_en_i,
    input  logic              tick_i,
    input  logic [SEL_W-1:0]  ref_ch_i,
    input  logic              sweep_plus_i,
    input  logic [DLY_W-1:0]  smp_dly_i,
    input  logic [INIT_W-1:0] init_mod_i,
    input  logic              irq_en_i,
    input  logic              cmp_out_i,
    input  logic [NUM_CH-1:0] flag_clr_i,
    output logic [SEL_W-1:0]  plus_sel_o,
    output logic [SEL_W-1:0]  minus_sel_o,
    output logic [NUM_CH-1:0] result_o,
    output logic [NUM_CH-1:0] changed_o,
    output logic              irq_o
);
    scan_state_e      state;
    logic             load_first;
    logic             capture;
    logic [SEL_W-1:0] cur_ch;
    logic [SEL_W-1:0] swept_sel;

    rrs_ctrl #(
        .INIT_W (INIT_W),
        .DLY_W  (DLY_W)
    ) ctrl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .scan_en_i    (scan_en_i),
        .tick_i       (tick_i),
        .init_mod_i   (init_mod_i),
        .smp_dly_i    (smp_dly_i),
        .state_o      (state),
        .load_first_o (load_first),
        .capture_o    (capture)
    );

    rrs_chan_ptr #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) ptr_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ref_i        (ref_ch_i),
        .load_first_i (load_first),
        .advance_i    (capture),
        .ch_o         (cur_ch)
    );

    rrs_result_bank #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .ch_i      (cur_ch),
        .cmp_i     (cmp_out_i),
        .clr_i     (flag_clr_i),
        .irq_en_i  (irq_en_i),
        .result_o  (result_o),
        .changed_o (changed_o),
        .irq_o     (irq_o)
    );

    assign swept_sel   = (state == ST_DWELL) ? cur_ch : ref_ch_i;
    assign plus_sel_o  = sweep_plus_i ? swept_sel : ref_ch_i;
    assign minus_sel_o = sweep_plus_i ? ref_ch_i : swept_sel;

    // R10: once idle, both inputs sit on the fixed channel
    a_r10_idle_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!scan_en_i && $past(!scan_en_i)) |-> ((plus_sel_o == ref_ch_i) && (minus_sel_o == ref_ch_i)));
endmodule

// File: tb/rr_cmp_scanner_tb_top.sv
`timescale 1ns/1ps
module rr_cmp_scanner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] ref_ch = '0;
    logic       sweep_plus = 1'b0;
    logic [1:0] smp_dly = '0;
    logic [5:0] init_mod = '0;
    logic       irq_en = 1'b0;
    logic       cmp = 1'b0;
    logic [7:0] clr = '0;
    logic [2:0] plus_sel, minus_sel;
    logic [7:0] result, changed;
    logic       irq;

    int checks = 0;
    int errors = 0;

    int         m_state, m_cnt, m_ch, m_w;
    logic [7:0] m_res, m_flg;
    logic       m_irq;

    always #2 clk = ~clk;

    rr_cmp_scanner dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .tick_i(tick),
        .ref_ch_i(ref_ch), .sweep_plus_i(sweep_plus), .smp_dly_i(smp_dly),
        .init_mod_i(init_mod), .irq_en_i(irq_en), .cmp_out_i(cmp),
        .flag_clr_i(clr), .plus_sel_o(plus_sel), .minus_sel_o(minus_sel),
        .result_o(result), .changed_o(changed), .irq_o(irq)
    );

    function automatic int next_ch(int c, int r);
        int n;
        n = (c + 1) % 8;
        if (n == r) n = (n + 1) % 8;
        return n;
    endfunction

    function automatic int hold_ticks_m1(int d);
        return (d == 0) ? 0 : d + 1;
    endfunction

    function automatic int settle_ticks(int m);
        return (m == 0) ? 64 : m;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_ch = 0; m_w = 0;
        m_res = '0; m_flg = '0; m_irq = 1'b0;
    endtask

    task automatic model_update();
        logic [7:0] setm;
        setm = '0;
        case (m_state)
            0: begin
                m_cnt = settle_ticks(init_mod);
                if (scan_en) m_state = 1;
            end
            1: begin
                if (!scan_en) m_state = 0;
                else if (tick) begin
                    if (m_cnt == 1) begin
                        m_state = 2;
                        m_ch = next_ch(7, ref_ch);
                        m_w = hold_ticks_m1(smp_dly);
                    end else m_cnt--;
                end
            end
            default: begin
                if (!scan_en) m_state = 0;
                else if (tick) begin
                    if (m_w == 0) begin
                        if (cmp != m_res[m_ch]) setm[m_ch] = 1'b1;
                        m_res[m_ch] = cmp;
                        m_ch = next_ch(m_ch, ref_ch);
                        m_w = hold_ticks_m1(smp_dly);
                    end else m_w--;
                end
            end
        endcase
        m_flg = (m_flg & ~clr) | setm;
        m_irq = irq_en && (|m_flg);
    endtask

    task automatic compare_all();
        int swept;
        swept = (m_state == 2) ? m_ch : int'(ref_ch);
        chk("R2 plus select", plus_sel, sweep_plus ? swept : int'(ref_ch));
        chk("R2 minus select", minus_sel, sweep_plus ? int'(ref_ch) : swept);
        chk("R5 result vector", result, m_res);
        chk("R6 changed flags", changed, m_flg);
        chk("R8 interrupt", irq, m_irq);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_update();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        scan_en = 1'b0; clr = '0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4217);

        // Reset state
        do_reset();
        chk("R1 result after reset", result, 0);
        chk("R1 flags after reset", changed, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 plus select after reset", plus_sel, 0);
        chk("R1 minus select after reset", minus_sel, 0);

        // Directed: minus swept, fixed channel 2, delay code 1, wait 3
        ref_ch = 3'd2; sweep_plus = 1'b0; smp_dly = 2'd1; init_mod = 6'd3;
        tick = 1'b1; cmp = 1'b0; scan_en = 1'b1;
        step(1);
        chk("R9 still waiting", minus_sel, 2);
        step(3);
        chk("R9 first channel after wait", minus_sel, 0);
        chk("R2 plus holds fixed", plus_sel, 2);
        step(3);
        chk("R4 code 1 holds three ticks", minus_sel, 1);
        step(3);
        chk("R3 skips fixed channel", minus_sel, 3);

        // Directed: zero modulus means 64 ticks
        do_reset();
        ref_ch = 3'd0; sweep_plus = 1'b1; smp_dly = 2'd0; init_mod = 6'd0;
        tick = 1'b1; scan_en = 1'b1;
        step(64);
        chk("R9 zero modulus not done at 63", plus_sel, 0);
        step(1);
        chk("R9 zero modulus done at 64", plus_sel, 1);

        // Directed: plus swept, fixed 7, code 0, collision and wrap
        do_reset();
        ref_ch = 3'd7; sweep_plus = 1'b1; smp_dly = 2'd0; init_mod = 6'd1;
        tick = 1'b1; cmp = 1'b1; irq_en = 1'b1; scan_en = 1'b1;
        step(1);
        chk("R2 swept shows fixed while waiting", plus_sel, 7);
        chk("R2 minus fixed", minus_sel, 7);
        step(1);
        chk("R9 first channel", plus_sel, 0);
        clr = 8'h01;
        step(1);
        chk("R7 set wins over clear", changed, 8'h01);
        chk("R5 capture of channel 0", result, 8'h01);
        chk("R4 code 0 holds one tick", plus_sel, 1);
        chk("R8 irq raised", irq, 1);
        step(1);
        chk("R7 clear takes effect", changed, 8'h02);
        clr = 8'h00;
        step(4);
        chk("R3 ascending order", plus_sel, 6);
        step(1);
        chk("R3 wraps past fixed 7", plus_sel, 0);
        chk("R5 all swept set", result, 8'h7F);
        step(1);
        chk("R6 equal capture sets nothing", changed, 8'h7E);
        cmp = 1'b0; irq_en = 1'b0; clr = 8'hFF;
        step(1);
        chk("R6 change sets flag", changed, 8'h02);
        chk("R8 irq off when disabled", irq, 0);
        clr = 8'h00; scan_en = 1'b0;
        step(1);
        chk("R10 idle select", plus_sel, 7);
        step(3);
        chk("R10 no capture when idle", result, 8'h7D);

        // Constrained random
        do_reset();
        for (int c = 0; c < 5000; c++) begin
            if (($urandom % 120) == 0) scan_en = ~scan_en;
            if (!scan_en && (($urandom % 4) == 0)) begin
                ref_ch = 3'($urandom % 8);
                sweep_plus = 1'($urandom % 2);
                smp_dly = 2'($urandom % 4);
                init_mod = (($urandom % 10) == 0) ? 6'd0 : 6'(1 + ($urandom % 5));
            end
            tick = (($urandom % 3) != 0);
            if (($urandom % 4) == 0) cmp = ~cmp;
            clr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 50) == 0) irq_en = ~irq_en;
            step(1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule